// File: doc/BRIEF.md
# Issue-Width Pipeline Balancing Controller

This block picks the issue width of a wide out-of-order core once per sampling window. At each window boundary it reads two activity figures measured over the window that just ended: the issue IPC and the floating-point IPC. It compares them against enter and exit thresholds supplied separately for each reduced mode, then keeps the current mode or moves to another one.

There are three states. `ST_FULL` is full-width issue with every functional unit enabled. `ST_W6` is six-wide issue with two floating-point units switched off, which leaves the machine unbalanced. `ST_W4` is four-wide issue with the whole second cluster of units switched off. The controller only decides the mode and drives the enables. Measuring IPC and gating unit clocks are done elsewhere.

A one-bit history keeps the controller out of `ST_W4` after a short dip in activity. The 4-wide entry test must pass at two window boundaries in a row before the controller enters that mode.

The named transitions are:
- FULL_TO_W6
- FULL_TO_W4
- W6_TO_FULL
- W6_TO_W4
- W4_TO_FULL

Top module: `issue_balance_ctrl`

## Requirements
- R1: While reset is held, and afterwards until the first transition, the outputs are: mode code 0 (`ST_FULL`), issue width 8, all four integer enables high, and all four FP enables high.
- R2: A mode change happens only on a clock edge where `win_end` is high. On edges with `win_end` low, every output keeps its value.
- R3: The 6-wide entry test is `fp_ipc < t6_in_fp` and `issue_ipc < t6_in_issue`. When it passes at a boundary in `ST_FULL` and FULL_TO_W4 is not taken, the controller moves to `ST_W6` (FULL_TO_W6).
- R4: The 6-wide exit test is `fp_ipc > t6_out_fp` or `issue_ipc > t6_out_issue`. When it passes at a boundary in `ST_W6`, the controller returns to `ST_FULL` (W6_TO_FULL). This transition takes priority over W6_TO_W4.
- R5: The 4-wide entry test is `issue_ipc < t4_in_issue` and `fp_ipc < t4_in_fp`. The controller enters `ST_W4` from `ST_FULL` (FULL_TO_W4) or from `ST_W6` (W6_TO_W4) only when this test passes at the current boundary and also passed at the previous boundary.
- R6: A boundary where the 4-wide entry test fails clears the history. After that, two new passing boundaries in a row are needed before the controller can enter `ST_W4`.
- R7: The 4-wide exit test is `issue_ipc > t4_out_issue` or `fp_ipc > t4_out_fp`. When it passes at a boundary in `ST_W4`, the controller goes straight to `ST_FULL` (W4_TO_FULL), never to `ST_W6`. Otherwise it stays in `ST_W4`, whatever the 6-wide tests give.
- R8: Each mode code drives a fixed set of outputs. Mode 1 (`ST_W6`) gives width 6, all integer enables high, and FP enables 4'b0011. Mode 2 (`ST_W4`) gives width 4, integer enables 4'b0011 and FP enables 4'b0011.
- R9: Each boundary causes at most one transition, and the new mode appears on the outputs right after the edge that sampled `win_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_end | input | 1 | High for one cycle at the end of a sampling window |
| issue_ipc | input | 4 | Issue IPC of the window that is ending |
| fp_ipc | input | 4 | Floating-point IPC of the window that is ending |
| t4_in_issue | input | 4 | 4-wide entry limit on issue IPC |
| t4_in_fp | input | 4 | 4-wide entry limit on FP IPC |
| t4_out_issue | input | 4 | 4-wide exit limit on issue IPC |
| t4_out_fp | input | 4 | 4-wide exit limit on FP IPC |
| t6_in_issue | input | 4 | 6-wide entry limit on issue IPC |
| t6_in_fp | input | 4 | 6-wide entry limit on FP IPC |
| t6_out_issue | input | 4 | 6-wide exit limit on issue IPC |
| t6_out_fp | input | 4 | 6-wide exit limit on FP IPC |
| mode_o | output | 2 | Current mode: 0 full, 1 six-wide, 2 four-wide |
| width_o | output | 4 | Allowed issue width |
| int_en_o | output | 4 | Integer unit enables |
| fp_en_o | output | 4 | Floating-point unit enables |

## Verification
The assertions assume three things about the inputs:
- `win_end` and every measurement and threshold are known values (no X).
- The IPC figures and thresholds are valid only when `win_end` is high.
- Nothing else about the inputs needs to be consistent, so a threshold set where the entry and exit tests overlap is still legal.

The stimulus respects this. It draws thresholds and IPC values from the whole 4-bit range with a fixed seed and raises `win_end` on roughly a third of cycles. Directed sequences add two boundaries in a row, a broken pair, and exits from each reduced mode.

// File: rtl/ibc_pkg.sv
package ibc_pkg;
    typedef enum logic [1:0] {
        ST_FULL = 2'd0,
        ST_W6   = 2'd1,
        ST_W4   = 2'd2
    } ibc_mode_e;

    typedef struct packed {
        logic en4;
        logic dis4;
        logic en6;
        logic dis6;
    } ibc_trig_t;
endpackage

// File: rtl/ibc_cond.sv
module ibc_cond #(
    parameter int IPC_W = 4
) (
    input  logic [IPC_W-1:0] issue_ipc,
    input  logic [IPC_W-1:0] fp_ipc,
    input  logic [IPC_W-1:0] t4_in_issue,
    input  logic [IPC_W-1:0] t4_in_fp,
    input  logic [IPC_W-1:0] t4_out_issue,
    input  logic [IPC_W-1:0] t4_out_fp,
    input  logic [IPC_W-1:0] t6_in_issue,
    input  logic [IPC_W-1:0] t6_in_fp,
    input  logic [IPC_W-1:0] t6_out_issue,
    input  logic [IPC_W-1:0] t6_out_fp,
    output ibc_pkg::ibc_trig_t trig
);
    always_comb begin
        trig.en4  = (issue_ipc < t4_in_issue) && (fp_ipc < t4_in_fp);
        trig.dis4 = (issue_ipc > t4_out_issue) || (fp_ipc > t4_out_fp);
        trig.en6  = (issue_ipc < t6_in_issue) && (fp_ipc < t6_in_fp);
        trig.dis6 = (issue_ipc > t6_out_issue) || (fp_ipc > t6_out_fp);
    end
endmodule

// File: rtl/ibc_fsm.sv
module ibc_fsm (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_end,
    input  ibc_pkg::ibc_trig_t trig,
    output ibc_pkg::ibc_mode_e state
);
    import ibc_pkg::*;

    ibc_mode_e state_q, state_d;
    logic      hist_q, hist_d;

    // Next-state selection; the history bit remembers the last boundary's 4-wide test
    always_comb begin
        state_d = state_q;
        hist_d  = hist_q;
        if (win_end) begin
            unique case (state_q)
                ST_FULL: begin
                    if (trig.en4 && hist_q)  state_d = ST_W4;   // FULL_TO_W4
                    else if (trig.en6)       state_d = ST_W6;   // FULL_TO_W6
                end
                ST_W6: begin
                    if (trig.dis6)                state_d = ST_FULL; // W6_TO_FULL
                    else if (trig.en4 && hist_q)  state_d = ST_W4;   // W6_TO_W4
                end
                ST_W4: begin
                    if (trig.dis4) state_d = ST_FULL;               // W4_TO_FULL
                end
                default: state_d = ST_FULL;
            endcase
            hist_d = trig.en4 && (state_d != ST_W4);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FULL;
            hist_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            hist_q  <= hist_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/ibc_decode.sv
module ibc_decode #(
    parameter int NUM_INT = 4,
    parameter int NUM_FP  = 4,
    parameter int FP_OFF6 = 2,
    parameter int W_FULL  = 8,
    parameter int W_SIX   = 6,
    parameter int W_FOUR  = 4,
    localparam int WW     = $clog2(W_FULL + 1)
) (
    input  ibc_pkg::ibc_mode_e state,
    output logic [1:0]         mode_o,
    output logic [WW-1:0]      width_o,
    output logic [NUM_INT-1:0] int_en_o,
    output logic [NUM_FP-1:0]  fp_en_o
);
    import ibc_pkg::*;

    localparam int FP_KEEP6 = NUM_FP - FP_OFF6;
    localparam int INT_HALF = NUM_INT / 2;
    localparam int FP_HALF  = NUM_FP / 2;

    always_comb begin
        mode_o = state;
        unique case (state)
            ST_W6:   width_o = WW'(W_SIX);
            ST_W4:   width_o = WW'(W_FOUR);
            default: width_o = WW'(W_FULL);
        endcase
    end

    for (genvar i = 0; i < NUM_INT; i++) begin : g_int
        assign int_en_o[i] = (state != ST_W4) || (i < INT_HALF);
    end

    for (genvar j = 0; j < NUM_FP; j++) begin : g_fp
        assign fp_en_o[j] = (state == ST_FULL)
                          || ((state == ST_W6) && (j < FP_KEEP6))
                          || ((state == ST_W4) && (j < FP_HALF));
    end
endmodule

// File: rtl/issue_balance_ctrl.sv
module issue_balance_ctrl #(
    parameter int IPC_W   = 4,
    parameter int NUM_INT = 4,
    parameter int NUM_FP  = 4,
    parameter int FP_OFF6 = 2,
    parameter int W_FULL  = 8,
    parameter int W_SIX   = 6,
    parameter int W_FOUR  = 4,
    localparam int WW     = $clog2(W_FULL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_end,
    input  logic [IPC_W-1:0]   issue_ipc,
    input  logic [IPC_W-1:0]   fp_ipc,
    input  logic [IPC_W-1:0]   t4_in_issue,
    input  logic [IPC_W-1:0]   t4_in_fp,
    input  logic [IPC_W-1:0]   t4_out_issue,
    input  logic [IPC_W-1:0]   t4_out_fp,
    input  logic [IPC_W-1:0]   t6_in_issue,
    input  logic [IPC_W-1:0]   t6_in_fp,
    input  logic [IPC_W-1:0]   t6_out_issue,
    input  logic [IPC_W-1:0]   t6_out_fp,
    output logic [1:0]         mode_o,
    output logic [WW-1:0]      width_o,
    output logic [NUM_INT-1:0] int_en_o,
    output logic [NUM_FP-1:0]  fp_en_o
);
    ibc_pkg::ibc_trig_t trig;
    ibc_pkg::ibc_mode_e state;

    ibc_cond #(.IPC_W(IPC_W)) u_cond (
        .issue_ipc(issue_ipc), .fp_ipc(fp_ipc),
        .t4_in_issue(t4_in_issue), .t4_in_fp(t4_in_fp),
        .t4_out_issue(t4_out_issue), .t4_out_fp(t4_out_fp),
        .t6_in_issue(t6_in_issue), .t6_in_fp(t6_in_fp),
        .t6_out_issue(t6_out_issue), .t6_out_fp(t6_out_fp),
        .trig(trig)
    );

    ibc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .win_end(win_end),
        .trig(trig), .state(state)
    );

    ibc_decode #(
        .NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .FP_OFF6(FP_OFF6),
        .W_FULL(W_FULL), .W_SIX(W_SIX), .W_FOUR(W_FOUR)
    ) u_dec (
        .state(state), .mode_o(mode_o), .width_o(width_o),
        .int_en_o(int_en_o), .fp_en_o(fp_en_o)
    );
endmodule

// File: rtl/ibc_chk.sv
module ibc_chk #(
    parameter int IPC_W   = 4,
    parameter int NUM_INT = 4,
    parameter int NUM_FP  = 4,
    parameter int FP_OFF6 = 2,
    parameter int WW      = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               win_end,
    input logic [IPC_W-1:0]   issue_ipc,
    input logic [IPC_W-1:0]   fp_ipc,
    input logic [IPC_W-1:0]   t4_in_issue,
    input logic [IPC_W-1:0]   t4_in_fp,
    input logic [IPC_W-1:0]   t4_out_fp,
    input logic [IPC_W-1:0]   t4_out_issue,
    input logic [1:0]         mode_o,
    input logic [WW-1:0]      width_o,
    input logic [NUM_INT-1:0] int_en_o,
    input logic [NUM_FP-1:0]  fp_en_o
);
    logic pass4, prev_pass4;
    assign pass4 = (issue_ipc < t4_in_issue) && (fp_ipc < t4_in_fp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       prev_pass4 <= 1'b0;
        else if (win_end) prev_pass4 <= pass4;
    end

    AST_HOLD_OFF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(mode_o) && $stable(width_o) && $stable(fp_en_o)); // R2

    AST_W4_TWO_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && mode_o != 2'd2 && !(pass4 && prev_pass4)) |=> mode_o != 2'd2); // R5

    AST_W4_EXIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |=> (mode_o == 2'd2 || mode_o == 2'd0)); // R7

    AST_W6_FP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1) |-> ($countones(fp_en_o) == NUM_FP - FP_OFF6 && width_o == WW'(6))); // R8

    AST_W4_CLUSTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> ($countones(int_en_o) == NUM_INT / 2 && width_o == WW'(4))); // R8

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3); // R9

    AST_FULL_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |-> (&int_en_o && &fp_en_o && width_o == WW'(8))); // R1
endmodule

bind issue_balance_ctrl ibc_chk #(
    .IPC_W(IPC_W), .NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .FP_OFF6(FP_OFF6), .WW(WW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .win_end(win_end),
    .issue_ipc(issue_ipc), .fp_ipc(fp_ipc),
    .t4_in_issue(t4_in_issue), .t4_in_fp(t4_in_fp),
    .t4_out_fp(t4_out_fp), .t4_out_issue(t4_out_issue),
    .mode_o(mode_o), .width_o(width_o), .int_en_o(int_en_o), .fp_en_o(fp_en_o)
);

// File: tb/issue_balance_ctrl_tb.sv
module issue_balance_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic win_end = 1'b0;
    logic [3:0] issue_ipc = '0, fp_ipc = '0;
    logic [3:0] t4_in_issue = '0, t4_in_fp = '0, t4_out_issue = '0, t4_out_fp = '0;
    logic [3:0] t6_in_issue = '0, t6_in_fp = '0, t6_out_issue = '0, t6_out_fp = '0;
    logic [1:0] mode_o;
    logic [3:0] width_o, int_en_o, fp_en_o;

    int tests = 0;
    int fails = 0;
    int m_mode = 0;
    bit m_hist = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    issue_balance_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .win_end(win_end),
        .issue_ipc(issue_ipc), .fp_ipc(fp_ipc),
        .t4_in_issue(t4_in_issue), .t4_in_fp(t4_in_fp),
        .t4_out_issue(t4_out_issue), .t4_out_fp(t4_out_fp),
        .t6_in_issue(t6_in_issue), .t6_in_fp(t6_in_fp),
        .t6_out_issue(t6_out_issue), .t6_out_fp(t6_out_fp),
        .mode_o(mode_o), .width_o(width_o), .int_en_o(int_en_o), .fp_en_o(fp_en_o)
    );

    function automatic int exp_width(int m);
        return (m == 1) ? 6 : (m == 2) ? 4 : 8;
    endfunction
    function automatic logic [3:0] exp_int(int m);
        return (m == 2) ? 4'b0011 : 4'b1111;
    endfunction
    function automatic logic [3:0] exp_fp(int m);
        return (m == 0) ? 4'b1111 : 4'b0011;
    endfunction

    task automatic check(string req);
        tests++;
        if (mode_o !== 2'(m_mode) || width_o !== 4'(exp_width(m_mode)) ||
            int_en_o !== exp_int(m_mode) || fp_en_o !== exp_fp(m_mode)) begin
            fails++;
            $display("FAIL %s: mode=%0d width=%0d int=%b fp=%b expected mode=%0d width=%0d int=%b fp=%b",
                     req, mode_o, width_o, int_en_o, fp_en_o,
                     m_mode, exp_width(m_mode), exp_int(m_mode), exp_fp(m_mode));
        end
    endtask

    // Reference model of one clock edge, from the requirement text
    task automatic model_step();
        bit e4, d4, e6, d6;
        int nm;
        if (!win_end) return;
        e4 = (issue_ipc < t4_in_issue) && (fp_ipc < t4_in_fp);
        d4 = (issue_ipc > t4_out_issue) || (fp_ipc > t4_out_fp);
        e6 = (issue_ipc < t6_in_issue) && (fp_ipc < t6_in_fp);
        d6 = (issue_ipc > t6_out_issue) || (fp_ipc > t6_out_fp);
        nm = m_mode;
        if (m_mode == 0)      nm = (e4 && m_hist) ? 2 : (e6 ? 1 : 0);
        else if (m_mode == 1) nm = d6 ? 0 : ((e4 && m_hist) ? 2 : 1);
        else                  nm = d4 ? 0 : 2;
        m_hist = e4 && (nm != 2);
        m_mode = nm;
    endtask

    task automatic cyc(bit we, int ii, int fi, string req);
        @(negedge clk);
        win_end = we; issue_ipc = 4'(ii); fp_ipc = 4'(fi);
        @(posedge clk);
        model_step();
        #2;
        check(req);
    endtask

    task automatic set_thr(int a, int b, int c, int d, int e, int f, int g, int h);
        @(negedge clk);
        win_end = 1'b0;
        t4_in_issue = 4'(a); t4_in_fp = 4'(b); t4_out_issue = 4'(c); t4_out_fp = 4'(d);
        t6_in_issue = 4'(e); t6_in_fp = 4'(f); t6_out_issue = 4'(g); t6_out_fp = 4'(h);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #2; check("R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        cyc(0, 0, 0, "R1 after reset");

        // 4-wide: enter below (3,3), exit above (9,9); 6-wide: enter below (6,6), exit above (10,10)
        set_thr(3, 3, 9, 9, 6, 6, 10, 10);
        cyc(0, 0, 0, "R2 no boundary");
        cyc(1, 1, 1, "R3 FULL_TO_W6 first low window");
        cyc(0, 15, 15, "R2 high IPC ignored off boundary");
        cyc(1, 1, 1, "R5 W6_TO_W4 second consecutive window");
        cyc(1, 8, 5, "R7 stays in W4 despite 6-wide tests");
        cyc(1, 12, 0, "R7 W4_TO_FULL");
        // broken pair
        cyc(1, 5, 5, "R3 FULL_TO_W6 without 4-wide pass");
        cyc(1, 1, 1, "R6 history was clear");
        cyc(1, 5, 1, "R6 pass broken");
        cyc(1, 1, 1, "R6 single pass not enough");
        cyc(1, 1, 1, "R5 two passes enter W4");
        cyc(1, 9, 9, "R7 at threshold stays");
        cyc(1, 10, 0, "R7 exit to FULL not W6");
        // FULL_TO_W4 directly, 6-wide entry disabled
        set_thr(3, 3, 9, 9, 0, 0, 10, 10);
        cyc(1, 2, 2, "R5 first pass in FULL");
        cyc(0, 2, 2, "R2 idle cycle keeps history");
        cyc(1, 2, 2, "R5 FULL_TO_W4");
        cyc(1, 15, 0, "R7 W4_TO_FULL");
        // priority of W6_TO_FULL over W6_TO_W4: 4-wide entry wide open, 6-wide exit on fp>0
        set_thr(15, 15, 15, 15, 15, 15, 15, 0);
        cyc(1, 1, 0, "R3 enter W6");
        cyc(1, 1, 1, "R4 exit wins over W4 entry");
        cyc(1, 1, 0, "R9 one step per boundary");

        for (int k = 0; k < 3000; k++) begin
            if ((k % 200) == 0)
                set_thr($urandom_range(15), $urandom_range(15), $urandom_range(15), $urandom_range(15),
                        $urandom_range(15), $urandom_range(15), $urandom_range(15), $urandom_range(15));
            cyc(($urandom_range(2) == 0), $urandom_range(15), $urandom_range(15), "R9 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule